// File: doc/BRIEF.md
# Reset Channel Controller

This block drives the active-low reset of one core or IP module from a single control and status register. Software uses a run bit to ask for the channel to be released or held in reset. A status bit reads the real output, so software polls it until the requested transition has taken effect. Three further controls can be set in the same register. A sticky lock freezes the run state. A self-clearing pulse bit gives one reset pulse of fixed minimum width and then leaves the channel running. Two policy bits choose whether the channel stays released during hibernate and during sleep.

Reset assertion is asynchronous. Release is synchronised to `clk_i` through a two-flop chain and then stretched by `HOLD_CYC` extra cycles. The register port and the reset target share `clk_i`. A core-type channel (`HAS_WDT` = 1) also has two watchdog enable bits. While an enabled watchdog request input is high, the channel is held in reset.

Top module: `rst_channel`

## Requirements
- R1: While `rst_ni` is low and after it rises, `reg_rdata_o` reads all zero and `tgt_rst_no` is 0. This means the channel is held, unlocked, both policy bits are clear and both watchdog enables are clear.
- R2: Writing 1 to bit 0 (run) releases the channel. `tgt_rst_no` and status bit 7 rise together, exactly 3+HOLD_CYC clock edges after the write edge (5 with defaults).
- R3: Writing 0 to bit 0 drives `tgt_rst_no` and status bit 7 low within the write cycle, without waiting for a further clock edge.
- R4: Writing 1 to bit 6 sets the lock. Only `rst_ni` clears it. While it is set, writes to bit 0 and bit 5 have no effect and the channel keeps its state.
- R5: Writing 1 to bit 5 while unlocked and idle holds the channel low for PULSE_W cycles and then runs the release of R2. The output is low for PULSE_W+3+HOLD_CYC cycles in total. Afterwards bit 0 reads 1 and the channel is running, whatever the run state was before the pulse.
- R6: Bit 5 reads 1 from the write edge until one cycle after the release, which is PULSE_W+4+HOLD_CYC cycles. While it reads 1, writes to bits 0 and 5 are ignored.
- R7: `lp_mode_i` is decoded as 0 active, 1 hibernate, 2 sleep and 3 active. In hibernate the channel is held unless bit 1 is 1. In sleep it is held unless bit 2 is 1.
- R8: Bits 3 and 4 enable `wdt_req_i[0]` and `wdt_req_i[1]`. An enabled request that is high pulls `tgt_rst_no` low at once. When the request drops, the channel is released again through the sequence of R2.
- R9: Bits 1 to 4 read back as written. Bits above 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and target clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| lp_mode_i | input | 2 | Current low-power mode |
| wdt_req_i | input | 2 | Watchdog reset requests, level |
| tgt_rst_no | output | 1 | Reset to the target, active low |

## Verification
The assertions assume several things about the inputs. `lp_mode_i` and `wdt_req_i` are glitch-free levels. A register write lasts exactly one cycle with `reg_we_i` high. `rst_ni` is the only thing that clears the lock. The bench changes every input only on falling edges and keeps each write strobe to one cycle. It sweeps every combination of run bit, policy bits and mode, and every combination of watchdog enables and requests, so an asynchronous hold source never changes at a sampling edge.

// File: rtl/rstch_pkg.sv
package rstch_pkg;
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned HIB_BIT   = 1;
  localparam int unsigned SLP_BIT   = 2;
  localparam int unsigned WD0_BIT   = 3;
  localparam int unsigned WD1_BIT   = 4;
  localparam int unsigned PULSE_BIT = 5;
  localparam int unsigned LOCK_BIT  = 6;
  localparam int unsigned STAT_BIT  = 7;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned WDT_N     = 2;

  typedef enum logic [1:0] {
    LP_ACTIVE = 2'd0,
    LP_HIB    = 2'd1,
    LP_SLEEP  = 2'd2,
    LP_RSVD   = 2'd3
  } lp_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HOLD = 2'd1,
    PS_WAIT = 2'd2
  } pulse_st_e;

  typedef struct packed {
    logic             lock;
    logic [WDT_N-1:0] wdt_en;
    logic             slp_keep;
    logic             hib_keep;
    logic             run;
  } ctl_s;
endpackage

// File: rtl/rstch_ctrl.sv
module rstch_ctrl
  import rstch_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PULSE_W = 8,
  parameter bit          HAS_WDT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              released_i,
  output ctl_s              ctl_o,
  output logic              pulse_busy_o,
  output logic              pulse_hold_o
);
  localparam int unsigned PCNT_W = (PULSE_W > 2) ? $clog2(PULSE_W) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PULSE_W - 1);

  ctl_s              ctl_q;
  pulse_st_e         st_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic              wr_ctl_ok;
  logic              pulse_req;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:LOCK_BIT+1];

  // run and pulse writes only when unlocked and no pulse in flight
  assign wr_ctl_ok = we_i && !ctl_q.lock && (st_q == PS_IDLE);
  assign pulse_req = wr_ctl_ok && wdata_i[PULSE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q.hib_keep <= wdata_i[HIB_BIT];
      ctl_q.slp_keep <= wdata_i[SLP_BIT];
      ctl_q.wdt_en   <= HAS_WDT ? wdata_i[WD1_BIT:WD0_BIT] : '0;
      if (wdata_i[LOCK_BIT]) ctl_q.lock <= 1'b1;
      if (wr_ctl_ok) ctl_q.run <= wdata_i[RUN_BIT] | wdata_i[PULSE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_IDLE;
      pcnt_q <= '0;
    end else begin
      unique case (st_q)
        PS_IDLE: if (pulse_req) begin
          st_q   <= PS_HOLD;
          pcnt_q <= '0;
        end
        PS_HOLD: if (pcnt_q == PCNT_LAST) st_q <= PS_WAIT;
                 else pcnt_q <= pcnt_q + 1'b1;
        PS_WAIT: if (released_i) st_q <= PS_IDLE;
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign ctl_o        = ctl_q;
  assign pulse_busy_o = (st_q != PS_IDLE);
  assign pulse_hold_o = (st_q == PS_HOLD);

  // R4
  lock_run_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> $stable(ctl_q.run));
  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> ctl_q.lock);
  // R4
  lock_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.lock && st_q == PS_IDLE) |=> st_q == PS_IDLE);
  // R6
  pulse_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_busy_o) |-> $past(released_i));
endmodule

// File: rtl/rstch_policy.sv
module rstch_policy
  import rstch_pkg::*;
#(
  parameter bit HAS_WDT = 1'b1
) (
  input  ctl_s             ctl_i,
  input  logic             pulse_hold_i,
  input  logic [1:0]       lp_mode_i,
  input  logic [WDT_N-1:0] wdt_req_i,
  output logic             hold_o
);
  logic lp_hold;
  logic wdt_hit;

  always_comb begin
    unique case (lp_mode_e'(lp_mode_i))
      LP_HIB:   lp_hold = !ctl_i.hib_keep;
      LP_SLEEP: lp_hold = !ctl_i.slp_keep;
      default:  lp_hold = 1'b0;
    endcase
  end

  if (HAS_WDT) begin : g_wdt
    logic [WDT_N-1:0] hit;
    for (genvar w = 0; w < WDT_N; w++) begin : g_src
      assign hit[w] = wdt_req_i[w] & ctl_i.wdt_en[w];
    end
    assign wdt_hit = |hit;
  end else begin : g_no_wdt
    logic unused_wdt;
    assign unused_wdt = ^{wdt_req_i, ctl_i.wdt_en};
    assign wdt_hit    = 1'b0;
  end

  assign hold_o = !ctl_i.run || pulse_hold_i || lp_hold || wdt_hit;
endmodule

// File: rtl/rstch_release.sv
module rstch_release #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic released_o
);
  localparam int unsigned CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC);

  logic             chain_rst_n;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rel_q;

  // assert asynchronously, release through the chain
  assign chain_rst_n = rst_ni & ~hold_i;

  always_ff @(posedge clk_i or negedge chain_rst_n) begin
    if (!chain_rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      rel_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
      if (sync_q[1] && !rel_q) begin
        if (cnt_q == CNT_LAST) rel_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign released_o = rel_q;

  // R2
  rel_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(sync_q[1]));
  // R3
  hold_forces_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !rel_q);
endmodule

// File: rtl/rst_channel.sv
module rst_channel
  import rstch_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PULSE_W  = 8,
  parameter int unsigned HOLD_CYC = 2,
  parameter bit          HAS_WDT  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [1:0]        lp_mode_i,
  input  logic [1:0]        wdt_req_i,
  output logic              tgt_rst_no
);
  ctl_s ctl;
  logic pulse_busy;
  logic pulse_hold;
  logic hold;
  logic released;

  rstch_ctrl #(
    .DATA_W (DATA_W),
    .PULSE_W(PULSE_W),
    .HAS_WDT(HAS_WDT)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .released_i  (released),
    .ctl_o       (ctl),
    .pulse_busy_o(pulse_busy),
    .pulse_hold_o(pulse_hold)
  );

  rstch_policy #(
    .HAS_WDT(HAS_WDT)
  ) i_policy (
    .ctl_i       (ctl),
    .pulse_hold_i(pulse_hold),
    .lp_mode_i   (lp_mode_i),
    .wdt_req_i   (wdt_req_i),
    .hold_o      (hold)
  );

  rstch_release #(
    .HOLD_CYC(HOLD_CYC)
  ) i_release (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .released_o(released)
  );

  always_comb begin
    reg_rdata_o                     = '0;
    reg_rdata_o[RUN_BIT]            = ctl.run;
    reg_rdata_o[HIB_BIT]            = ctl.hib_keep;
    reg_rdata_o[SLP_BIT]            = ctl.slp_keep;
    reg_rdata_o[WD1_BIT:WD0_BIT]    = ctl.wdt_en;
    reg_rdata_o[PULSE_BIT]          = pulse_busy;
    reg_rdata_o[LOCK_BIT]           = ctl.lock;
    reg_rdata_o[STAT_BIT]           = released;
  end

  assign tgt_rst_no = released;

  // R1
  run_off_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.run |-> !tgt_rst_no);
  // R5
  pulse_hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_hold |-> !tgt_rst_no);
endmodule

// File: tb/test_rst_channel.sv
module test_rst_channel;
  localparam int PW  = 8;
  localparam int HC  = 2;
  localparam int LAT = 3 + HC;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  lp_mode_i = 2'd0;
  logic [1:0]  wdt_req_i = 2'd0;
  logic        tgt_rst_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rst_channel #(.DATA_W(32), .PULSE_W(PW), .HOLD_CYC(HC), .HAS_WDT(1'b1)) i_rst_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .lp_mode_i(lp_mode_i), .wdt_req_i(wdt_req_i),
    .tgt_rst_no(tgt_rst_no)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    reg_wdata_i = '0;
  endtask

  task automatic por();
    rst_ni = 1'b0;
    reg_we_i = 1'b0;
    lp_mode_i = 2'd0;
    wdt_req_i = 2'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wait_rel(output int n);
    n = 0;
    while (!tgt_rst_no && n < 200) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic pulse_run(logic [31:0] d, output int lows, output int busy);
    wr(d);
    lows = 0;
    busy = 0;
    for (int i = 0; i < 60; i++) begin
      if (!tgt_rst_no) lows++;
      if (reg_rdata_o[5]) busy++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    int n, lows, busy;
    por();
    // R1 reset state
    chk("R1 rdata", int'(reg_rdata_o), 0);
    chk("R1 tgt", int'(tgt_rst_no), 0);

    // R2 release latency
    wr(32'h1);
    wait_rel(n);
    chk("R2 latency", n, LAT);
    chk("R2 status", int'(reg_rdata_o[7]), 1);

    // R3 asynchronous assertion within the write cycle
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_wdata_i = 32'h0;
    @(posedge clk_i);
    #1;
    chk("R3 tgt", int'(tgt_rst_no), 0);
    chk("R3 status", int'(reg_rdata_o[7]), 0);
    @(negedge clk_i);
    reg_we_i = 1'b0;

    // R5 and R6: pulse from held state
    pulse_run(32'h20, lows, busy);
    chk("R5 low from held", lows, PW + LAT);
    chk("R6 busy from held", busy, PW + LAT + 1);
    chk("R5 run after", int'(reg_rdata_o[0]), 1);
    chk("R5 running", int'(tgt_rst_no), 1);

    // R5 and R6: pulse from running state
    pulse_run(32'h21, lows, busy);
    chk("R5 low from run", lows, PW + LAT);
    chk("R6 busy from run", busy, PW + LAT + 1);

    // R6: writes during the pulse are ignored
    wr(32'h21);
    wr(32'h0);
    repeat (40) @(negedge clk_i);
    chk("R6 run kept", int'(reg_rdata_o[0]), 1);
    chk("R6 tgt", int'(tgt_rst_no), 1);
    chk("R6 bit clear", int'(reg_rdata_o[5]), 0);

    // R4 lock
    wr(32'h41);
    wr(32'h0);
    repeat (LAT + 3) @(negedge clk_i);
    chk("R4 run kept", int'(reg_rdata_o[0]), 1);
    chk("R4 tgt kept", int'(tgt_rst_no), 1);
    chk("R4 lock set", int'(reg_rdata_o[6]), 1);
    pulse_run(32'h20, lows, busy);
    chk("R4 pulse blocked low", lows, 0);
    chk("R4 pulse blocked bit", busy, 0);
    wr(32'h0);
    chk("R4 sticky", int'(reg_rdata_o[6]), 1);
    por();
    chk("R4 por clears", int'(reg_rdata_o[6]), 0);

    // R9 readback
    wr(32'hFFFF_FF1E);
    chk("R9 readback", int'(reg_rdata_o), 32'h1E);

    // R7 low-power policy sweep
    for (int run = 0; run < 2; run++) begin
      for (int pol = 0; pol < 4; pol++) begin
        for (int md = 0; md < 4; md++) begin
          int exp;
          wr(32'(run | (pol << 1)));
          lp_mode_i = 2'(md);
          repeat (LAT + 2) @(negedge clk_i);
          exp = run;
          if (md == 1 && (pol & 1) == 0) exp = 0;
          if (md == 2 && (pol & 2) == 0) exp = 0;
          chk("R7 policy", int'(tgt_rst_no), exp);
          lp_mode_i = 2'd0;
        end
      end
    end

    // R8 watchdog sweep
    for (int en = 0; en < 4; en++) begin
      wr(32'(1 | (en << 3)));
      repeat (LAT + 2) @(negedge clk_i);
      chk("R9 wdt enable readback", int'(reg_rdata_o[4:3]), en);
      for (int rq = 0; rq < 4; rq++) begin
        wdt_req_i = 2'(rq);
        #1;
        chk("R8 immediate", int'(tgt_rst_no), ((en & rq) == 0) ? 1 : 0);
        @(negedge clk_i);
        wdt_req_i = 2'd0;
        wait_rel(n);
        chk("R8 recovery", int'(tgt_rst_no), 1);
      end
    end

    done = 1'b1;
    summary();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end
endmodule